// File: doc/BRIEF.md
# Asynchronous Memory Chip-Select Timing Controller

This block produces the pin waveforms for a single chip-select window of an asynchronous external memory. An internal agent hands it one access at a time over a valid/ready port: an address, write data and a direction flag. The controller walks the access through three timed phases, setup, strobe and hold. It drives chip select, output enable, write enable, the address bus and the write-data bus, and it returns read data with a one-cycle valid pulse.

The lengths of the three phases are programmed separately for reads and for writes. A mode input chooses whether chip select covers the whole access or only the strobe. An enable lets an external wait line stretch the strobe, and a bus-size field chooses between a full 16-bit data path and a narrow 8-bit one. All pin outputs come from registers. Configuration is sampled each time a phase begins, so it must stay stable while an access is in flight.

Top module: `amem_cs_timer`

## Requirements
- R1: Setup, strobe and hold lengths come from six separate inputs, three for reads and three for writes. A programmed count N gives exactly N clock cycles in that phase, and a count of 0 gives 1 cycle.
- R2: With setup 2, strobe 3 and hold 2, the pins show exactly 2 setup cycles, 3 strobe cycles and 2 hold cycles. The first setup cycle is the cycle after the accepting clock edge.
- R3: With `cfg_cs_strobe_only`=0, `mem_cs_n` is low through setup, strobe and hold. With it at 1, `mem_cs_n` is low only in the strobe phase. In both modes it is high when idle.
- R4: `mem_oe_n` is low exactly during the strobe of a read, and `mem_we_n` is low exactly during the strobe of a write. They are never low together.
- R5: `mem_addr` carries the request address from the first setup cycle through the last hold cycle and is zero when idle. `mem_dout_en` is 1 and `mem_dout` carries the write data over the same span of a write. Otherwise `mem_dout_en` is 0 and `mem_dout` is 0.
- R6: Read data is sampled from `mem_din` on the last strobe cycle, after any wait extension. It appears on `rsp_rdata`, with `rsp_valid` high for exactly one cycle, in the first hold cycle. Writes produce no `rsp_valid`.
- R7: `req_ready` is low from the first setup cycle until hold completes and is high when idle. Only one access is outstanding, and request inputs that change while busy do not alter the access in flight.
- R8: With `cfg_wait_en`=1, the strobe does not end while `mem_wait` is high on a cycle where the strobe count has expired. With `cfg_wait_en`=0, `mem_wait` has no effect on timing.
- R9: `cfg_bus_size` of 1, 2 or 3 selects the full 16-bit bus. A value of 0 selects an 8-bit bus: the upper 8 bits of `mem_dout` are driven 0, and the upper 8 bits of `rsp_rdata` read as 0.
- R10: After reset `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` and `rsp_valid` are 0, `mem_addr` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_strobe | input | CNT_W | Read strobe cycles |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_strobe | input | CNT_W | Write strobe cycles |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| cfg_cs_strobe_only | input | 1 | 1: chip select only in strobe |
| cfg_wait_en | input | 1 | 1: wait input may stretch the strobe |
| cfg_bus_size | input | 2 | 0: 8-bit bus, otherwise 16-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_dout | output | DATA_W | Write data pins |
| mem_dout_en | output | 1 | Data pin drive enable |
| mem_din | input | DATA_W | Read data pins |
| mem_wait | input | 1 | External wait, active high |

## Verification
Two events can fall in the same cycle: the expiry of the programmed strobe count and the release of the wait line. On that cycle the read sample is taken and the phase moves to hold. The bench provokes this by raising `mem_wait` for a chosen number of strobe cycles. That number is placed just below, exactly at and beyond the programmed strobe length, and the same patterns are also applied with the enable off. It judges the outcome by the strobe length observed on the pins and by which cycle's `mem_din` value comes back in the response.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

endpackage

// File: rtl/amem_phase_ctrl.sv
module amem_phase_ctrl
  import amem_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_rd_strobe,
  input  logic [CNT_W-1:0] cfg_rd_hold,
  input  logic [CNT_W-1:0] cfg_wr_setup,
  input  logic [CNT_W-1:0] cfg_wr_strobe,
  input  logic [CNT_W-1:0] cfg_wr_hold,
  input  logic             cfg_wait_en,
  input  logic             mem_wait,
  output logic             accept,
  output phase_t           phase_d,
  output logic             wr_d,
  output logic             rd_capture
);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q;
  logic             stall;

  // A zero count still yields one cycle; the counter holds cycles left minus one.
  function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - CNT_W'(1);
  endfunction

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    wr_d       = wr_q;
    accept     = 1'b0;
    rd_capture = 1'b0;
    stall      = cfg_wait_en & mem_wait;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          wr_d    = req_write;
          phase_d = PH_SETUP;
          cnt_d   = reload(req_write ? cfg_wr_setup : cfg_rd_setup);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = reload(wr_q ? cfg_wr_strobe : cfg_rd_strobe);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!stall) begin
          rd_capture = !wr_q;
          phase_d    = PH_HOLD;
          cnt_d      = reload(wr_q ? cfg_wr_hold : cfg_rd_hold);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  // R8: without the enable an expired strobe always moves on to hold
  a_r8_wait_ignored: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STROBE && cnt_q == '0 && !cfg_wait_en) |=> (phase_q == PH_HOLD));

  // R1: an expired setup count always hands over to the strobe
  a_r1_setup_to_strobe: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP && cnt_q == '0) |=> (phase_q == PH_STROBE));

  // R7: the write flag of an access in flight never changes
  a_r7_dir_stable: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && phase_q != PH_HOLD) |=> $stable(wr_q));

endmodule

// File: rtl/amem_pin_drive.sv
module amem_pin_drive
  import amem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_d,
  input  logic              wr_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic              cs_strobe_only,
  input  logic              bus_wide,
  output logic              req_ready,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en
);

  localparam int NARROW_W = DATA_W / 2;

  logic              active, strobe;
  logic [DATA_W-1:0] wdata_sized;

  assign active      = (phase_d != PH_IDLE);
  assign strobe      = (phase_d == PH_STROBE);
  assign wdata_sized = bus_wide ? wdata_d
                                : {{(DATA_W-NARROW_W){1'b0}}, wdata_d[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready   <= 1'b1;
      mem_cs_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      req_ready   <= !active;
      mem_cs_n    <= !(cs_strobe_only ? strobe : active);
      mem_oe_n    <= !(strobe && !wr_d);
      mem_we_n    <= !(strobe && wr_d);
      mem_addr    <= active ? addr_d : '0;
      mem_dout    <= (active && wr_d) ? wdata_sized : '0;
      mem_dout_en <= active && wr_d;
    end
  end

  // R4: read and write strobes never overlap
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R3: any strobe lies inside chip select, in either mode
  a_r3_cs_covers_strobe: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  // R7: no access may be in flight while ready is shown
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && !mem_dout_en));

endmodule

// File: rtl/amem_rd_capture.sv
module amem_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              bus_wide,
  input  logic [DATA_W-1:0] mem_din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int NARROW_W = DATA_W / 2;

  logic [DATA_W-1:0] din_sized;

  assign din_sized = bus_wide ? mem_din
                              : {{(DATA_W-NARROW_W){1'b0}}, mem_din[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= din_sized;
    end
  end

  // R6: a response is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: returned data does not move outside a capture
  a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rsp_rdata));

endmodule

// File: rtl/amem_cs_timer.sv
module amem_cs_timer
  import amem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_rd_setup,
  input  logic [CNT_W-1:0]  cfg_rd_strobe,
  input  logic [CNT_W-1:0]  cfg_rd_hold,
  input  logic [CNT_W-1:0]  cfg_wr_setup,
  input  logic [CNT_W-1:0]  cfg_wr_strobe,
  input  logic [CNT_W-1:0]  cfg_wr_hold,
  input  logic              cfg_cs_strobe_only,
  input  logic              cfg_wait_en,
  input  logic [1:0]        cfg_bus_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_wait
);

  logic              accept, wr_d, rd_capture, bus_wide;
  phase_t            phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  assign bus_wide = (cfg_bus_size != 2'd0);
  assign addr_d   = accept ? req_addr  : addr_q;
  assign wdata_d  = accept ? req_wdata : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  amem_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .cfg_rd_setup  (cfg_rd_setup),
    .cfg_rd_strobe (cfg_rd_strobe),
    .cfg_rd_hold   (cfg_rd_hold),
    .cfg_wr_setup  (cfg_wr_setup),
    .cfg_wr_strobe (cfg_wr_strobe),
    .cfg_wr_hold   (cfg_wr_hold),
    .cfg_wait_en   (cfg_wait_en),
    .mem_wait      (mem_wait),
    .accept        (accept),
    .phase_d       (phase_d),
    .wr_d          (wr_d),
    .rd_capture    (rd_capture)
  );

  amem_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk            (clk),
    .rst            (rst),
    .phase_d        (phase_d),
    .wr_d           (wr_d),
    .addr_d         (addr_d),
    .wdata_d        (wdata_d),
    .cs_strobe_only (cfg_cs_strobe_only),
    .bus_wide       (bus_wide),
    .req_ready      (req_ready),
    .mem_cs_n       (mem_cs_n),
    .mem_oe_n       (mem_oe_n),
    .mem_we_n       (mem_we_n),
    .mem_addr       (mem_addr),
    .mem_dout       (mem_dout),
    .mem_dout_en    (mem_dout_en)
  );

  amem_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .capture   (rd_capture),
    .bus_wide  (bus_wide),
    .mem_din   (mem_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R7: the address on the pins is frozen while an access is in flight
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_amem_cs_timer.sv
module tb_amem_cs_timer;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
  logic [CNT_W-1:0]  cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
  logic              cfg_cs_strobe_only = 1'b0, cfg_wait_en = 1'b0;
  logic [1:0]        cfg_bus_size = 2'd1;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_dout;
  logic [DATA_W-1:0] mem_din = '0;
  logic              mem_wait = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  amem_cs_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_cs_strobe_only(cfg_cs_strobe_only), .cfg_wait_en(cfg_wait_en),
    .cfg_bus_size(cfg_bus_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [DATA_W-1:0] sized(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    return (sz == 2'd0) ? {8'h00, v[7:0]} : v;
  endfunction

  // One access, checked cycle by cycle. wc: strobe cycles with mem_wait high.
  task automatic access(input string tag, input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int wc, input bit poke);
    int s, t0, tl, h, last;
    logic [DATA_W-1:0] exp_rd;
    s  = eff(wr ? int'(cfg_wr_setup)  : int'(cfg_rd_setup));
    t0 = eff(wr ? int'(cfg_wr_strobe) : int'(cfg_rd_strobe));
    h  = eff(wr ? int'(cfg_wr_hold)   : int'(cfg_rd_hold));
    tl = cfg_wait_en ? ((wc + 1 > t0) ? wc + 1 : t0) : t0;
    last   = s + tl + h;
    exp_rd = '0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      bit in_st, act, is_rsp;
      @(negedge clk);
      in_st  = (k >= s) && (k < s + tl);
      act    = (k < last);
      is_rsp = !wr && (k == s + tl);
      chk({tag, " R3 cs"}, 32'(mem_cs_n), 32'(!(cfg_cs_strobe_only ? in_st : act)));
      chk({tag, " R4 oe"}, 32'(mem_oe_n), 32'(!(in_st && !wr)));
      chk({tag, " R4 we"}, 32'(mem_we_n), 32'(!(in_st && wr)));
      chk({tag, " R5 addr"}, 32'(mem_addr), act ? 32'(a) : 32'h0);
      chk({tag, " R5 dout_en"}, 32'(mem_dout_en), 32'(act && wr));
      chk({tag, " R9 dout"}, 32'(mem_dout), (act && wr) ? 32'(sized(d, cfg_bus_size)) : 32'h0);
      chk({tag, " R7 ready"}, 32'(req_ready), 32'(!act));
      chk({tag, " R6 rsp_valid"}, 32'(rsp_valid), 32'(is_rsp));
      if (is_rsp) chk({tag, " R6 rdata"}, 32'(rsp_rdata), 32'(sized(exp_rd, cfg_bus_size)));
      // drive inputs for this cycle
      mem_wait = in_st && ((k - s) < wc);
      mem_din  = DATA_W'($urandom);
      if (k == s + tl - 1) exp_rd = mem_din;
      if (poke) begin
        req_valid = (k < last - 1);
        req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      end else if (k == 0) begin
        req_valid = 1'b0;
      end
    end
    mem_wait  = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input int rs, rt, rh, ws, wt, wh);
    cfg_rd_setup = CNT_W'(rs); cfg_rd_strobe = CNT_W'(rt); cfg_rd_hold = CNT_W'(rh);
    cfg_wr_setup = CNT_W'(ws); cfg_wr_strobe = CNT_W'(wt); cfg_wr_hold = CNT_W'(wh);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 cs", 32'(mem_cs_n), 32'd1);
    chk("R10 oe", 32'(mem_oe_n), 32'd1);
    chk("R10 we", 32'(mem_we_n), 32'd1);
    chk("R10 dout_en", 32'(mem_dout_en), 32'd0);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 addr", 32'(mem_addr), 32'd0);
    chk("R10 ready", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);

    // R2 example programming, both directions, normal chip select
    set_cfg(2, 3, 2, 2, 3, 2);
    cfg_bus_size = 2'd1;
    access("R2 wr", 1'b1, 20'h12345, 16'h1234, 0, 0);
    access("R2 rd", 1'b0, 20'h00ABC, 16'h0000, 0, 0);
    // R3 strobe-only chip select
    cfg_cs_strobe_only = 1'b1;
    access("R3 wr", 1'b1, 20'h0F0F0, 16'hBEEF, 0, 0);
    access("R3 rd", 1'b0, 20'h0F0F1, 16'h0000, 0, 0);
    cfg_cs_strobe_only = 1'b0;
    // R1 zero counts give one cycle; distinct read/write values
    set_cfg(0, 0, 0, 5, 1, 4);
    access("R1 rd zero", 1'b0, 20'h00001, 16'h0, 0, 0);
    access("R1 wr", 1'b1, 20'h00002, 16'hA5A5, 0, 0);
    // R8 wait corners: below, at and beyond strobe count; enabled and ignored
    set_cfg(1, 3, 1, 1, 3, 1);
    cfg_wait_en = 1'b1;
    access("R8 rd wc2", 1'b0, 20'h00010, 16'h0, 2, 0);
    access("R8 rd wc3", 1'b0, 20'h00011, 16'h0, 3, 0);
    access("R8 wr wc6", 1'b1, 20'h00012, 16'h7777, 6, 0);
    access("R8 rd wc5", 1'b0, 20'h00013, 16'h0, 5, 0);
    cfg_wait_en = 1'b0;
    access("R8 ignored", 1'b0, 20'h00014, 16'h0, 6, 0);
    // R9 narrow bus
    cfg_bus_size = 2'd0;
    access("R9 wr8", 1'b1, 20'h00020, 16'hFACE, 0, 0);
    access("R9 rd8", 1'b0, 20'h00021, 16'h0, 0, 0);
    cfg_bus_size = 2'd3;
    access("R9 rd16", 1'b0, 20'h00022, 16'h0, 0, 0);
    // R7 request changes while busy are ignored
    cfg_bus_size = 2'd1;
    access("R7 poke wr", 1'b1, 20'h00AAA, 16'h5555, 0, 1);
    access("R7 poke rd", 1'b0, 20'h00BBB, 16'h0, 0, 1);

    // R1 random mix
    for (int i = 0; i < 60; i++) begin
      set_cfg($urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
              $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5));
      cfg_cs_strobe_only = 1'($urandom);
      cfg_wait_en        = 1'($urandom);
      cfg_bus_size       = 2'($urandom);
      access("R1 rand", 1'($urandom), ADDR_W'($urandom), DATA_W'($urandom),
             $urandom_range(0, 7), 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule